// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table is indexed by a global history register that holds the most recent branch directions, newest in bit 0. A mode input selects how the index is formed. The index is either the history alone, or the history XORed with a slice of the branch PC that skips the low alignment bits.

**Fetch side.** A lookup presents a valid strobe and a PC. One cycle later the block returns:
- the predicted direction, and
- the exact history value that formed the index.

At the same edge the predicted bit is shifted into the history. The next lookup therefore already sees it.

**Resolve side.** When the branch resolves, the pipeline hands back:
- the snapshot that travelled with the branch,
- its PC,
- the actual outcome, and
- a mispredict flag.

The counter addressed by the snapshot is trained. On a misprediction the history is rebuilt from the snapshot and the real outcome.

Top module: `gbp_predictor`

## Requirements
- R1: While `rst` is high and after it falls, the history register is zero, every counter holds weakly not-taken (2'b01), and `pred_valid`, `pred_taken` and `pred_hist` read zero.
- R2: A lookup accepted at a clock edge sets `pred_valid` and `pred_taken` after that edge. `pred_taken` is the MSB of the addressed counter (2'b10 and 2'b11 mean taken). With no lookup, `pred_valid` is low after the next edge.
- R3: At each lookup the history shifts left by one and the predicted bit enters bit 0. A second lookup on the following cycle therefore uses the updated history.
- R4: `pred_hist` returns the history value that formed the index of that lookup, taken before the shift.
- R5: A resolve (`rs_valid` high) moves the counter addressed by `rs_hist` (and by `rs_pc` in XOR mode) one step toward the outcome. A taken outcome increments the counter, saturating at 2'b11. A not-taken outcome decrements it, saturating at 2'b00. The live history register never forms this index.
- R6: A resolve with `rs_mispredict` high loads the history with `{rs_hist[K-2:0], rs_taken}`. This wins over a lookup shift in the same cycle.
- R7: A resolve with `rs_mispredict` low leaves the history unchanged.
- R8: With `gshare_en` low the index is the history alone and the PC has no effect. With `gshare_en` high the index is `history ^ pc[SKIP+K-1:SKIP]`, with SKIP = 1 by default.
- R9: A lookup and a resolve that hit the same counter in the same cycle return the value the counter held before the update.
- R10: While `rs_valid` is low, `rs_mispredict`, `rs_taken`, `rs_hist` and `rs_pc` change neither the counters nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gshare_en | input | 1 | 0: history-only index; 1: history XOR PC index |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC of the branch being looked up |
| pred_valid | output | 1 | Registered: a prediction is presented |
| pred_taken | output | 1 | Registered predicted direction |
| pred_hist | output | K | Registered history snapshot used by the lookup |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_mispredict | input | 1 | The resolving branch was mispredicted |
| rs_hist | input | K | Snapshot that travelled with the resolving branch |
| rs_pc | input | PC_W | PC of the resolving branch |

## Verification
The hardest case to reach from the ports is a counter at an index that is not the current history, together with a history set to an arbitrary value. Lookups alone only ever walk the history through predicted bits. The stimulus steers the history with mispredict resolves: a chosen snapshot and outcome load any wanted value, which allows one counter to be trained and another to be probed. Two cases are driven with a lookup and a resolve in one cycle:
- both hit the same counter, which shows that the old value is returned;
- a lookup coincides with a mispredict, which shows that restoration takes priority.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // one saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
    else       return (c == CTR_MIN) ? c : ctr_t'(c - 2'd1);
  endfunction

endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int K    = 10,
  parameter int PC_W = 32,
  parameter int SKIP = 1
) (
  input  logic [K-1:0]    hist,
  input  logic [PC_W-1:0] pc,
  input  logic            xor_en,
  output logic [K-1:0]    idx
);

  localparam int TOP = SKIP + K;

  logic [K-1:0] pc_slice;
  assign pc_slice = pc[TOP-1:SKIP];

  generate
    if (TOP < PC_W && SKIP > 0) begin : g_both_sides
      logic unused_pc_bits;
      assign unused_pc_bits = ^{pc[PC_W-1:TOP], pc[SKIP-1:0]};
    end else if (SKIP > 0) begin : g_low_side
      logic unused_pc_bits;
      assign unused_pc_bits = ^pc[SKIP-1:0];
    end else if (TOP < PC_W) begin : g_high_side
      logic unused_pc_bits;
      assign unused_pc_bits = ^pc[PC_W-1:TOP];
    end
  endgenerate

  assign idx = xor_en ? (hist ^ pc_slice) : hist;

endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
  import gbp_pkg::*;
#(
  parameter int K = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] rd_idx,
  output logic         rd_taken,
  input  logic         wr_en,
  input  logic [K-1:0] wr_idx,
  input  logic         wr_taken
);

  localparam int DEPTH = 1 << K;

  ctr_t mem [DEPTH];

  // asynchronous read: a same-cycle write is seen only after the edge (R9)
  assign rd_taken = mem[rd_idx][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  // R5: counters stop at both ends
  p_sat_high_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);

  p_sat_low_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);

endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int K = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         restore_en,
  input  logic [K-1:0] restore_hist,
  input  logic         restore_bit,
  output logic [K-1:0] hist
);

  always_ff @(posedge clk) begin
    if (rst)             hist <= '0;
    else if (restore_en) hist <= {restore_hist[K-2:0], restore_bit};
    else if (shift_en)   hist <= {hist[K-2:0], shift_bit};
  end

  // R6: rollback from the snapshot, even when a lookup shares the cycle
  p_restore_r6: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> hist == {$past(restore_hist[K-2:0]), $past(restore_bit)});

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor
  import gbp_pkg::*;
#(
  parameter int K    = 10,
  parameter int PC_W = 32,
  parameter int SKIP = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gshare_en,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [K-1:0]    pred_hist,
  input  logic            rs_valid,
  input  logic            rs_taken,
  input  logic            rs_mispredict,
  input  logic [K-1:0]    rs_hist,
  input  logic [PC_W-1:0] rs_pc
);

  logic [K-1:0] ghr;
  logic [K-1:0] lk_idx;
  logic [K-1:0] rs_idx;
  logic         lk_dir;
  logic         rollback;

  assign rollback = rs_valid & rs_mispredict;

  gbp_index #(.K(K), .PC_W(PC_W), .SKIP(SKIP)) u_lk_idx (
    .hist(ghr), .pc(lk_pc), .xor_en(gshare_en), .idx(lk_idx)
  );

  // training uses the snapshot, never the live history
  gbp_index #(.K(K), .PC_W(PC_W), .SKIP(SKIP)) u_rs_idx (
    .hist(rs_hist), .pc(rs_pc), .xor_en(gshare_en), .idx(rs_idx)
  );

  gbp_pht #(.K(K)) u_pht (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_taken(lk_dir),
    .wr_en(rs_valid), .wr_idx(rs_idx), .wr_taken(rs_taken)
  );

  gbp_history #(.K(K)) u_hist (
    .clk(clk), .rst(rst),
    .shift_en(lk_valid), .shift_bit(lk_dir),
    .restore_en(rollback), .restore_hist(rs_hist), .restore_bit(rs_taken),
    .hist(ghr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_taken <= lk_dir;
        pred_hist  <= ghr;
      end
    end
  end

  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);

  p_snapshot_r4: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_hist == $past(ghr));

  p_spec_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !rollback) |=> ghr == {$past(ghr[K-2:0]), pred_taken});

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!lk_valid && !rollback) |=> $stable(ghr));

endmodule

// File: tb/sim_gbp_predictor.sv
`timescale 1ns/1ps
module sim_gbp_predictor;

  localparam int K    = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            gshare_en = 1'b0;
  logic            lk_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            pred_valid;
  logic            pred_taken;
  logic [K-1:0]    pred_hist;
  logic            rs_valid = 1'b0;
  logic            rs_taken = 1'b0;
  logic            rs_mispredict = 1'b0;
  logic [K-1:0]    rs_hist = '0;
  logic [PC_W-1:0] rs_pc = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  gbp_predictor #(.K(K), .PC_W(PC_W), .SKIP(1)) u0 (
    .clk(clk), .rst(rst), .gshare_en(gshare_en),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_mispredict(rs_mispredict),
    .rs_hist(rs_hist), .rs_pc(rs_pc)
  );

  // vector: [23] op (0 lookup, 1 resolve) [22:13] hist [12] taken [11] misp
  //         [10] expected direction [9:0] expected snapshot (lookups only)
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h000}, // ctr[0]=01 -> NT
    {1'b1, 10'h000, 1'b1, 1'b1, 1'b0, 10'h000}, // ctr[0]=10, ghr=1
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h001}, // ghr->2
    {1'b1, 10'h000, 1'b1, 1'b0, 1'b0, 10'h000}, // ctr[0]=11, ghr kept (R7)
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h002}, // ghr->4
    {1'b1, 10'h000, 1'b0, 1'b1, 1'b0, 10'h000}, // ctr[0]=10, ghr=0
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000}, // taken, ghr->1
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h001}, // back to back (R3), ghr->2
    {1'b1, 10'h000, 1'b1, 1'b0, 1'b0, 10'h000}, // ctr[0]=11 using snapshot 0
    {1'b1, 10'h000, 1'b1, 1'b0, 1'b0, 10'h000}, // stays 11
    {1'b1, 10'h200, 1'b0, 1'b1, 1'b0, 10'h000}, // ctr[200]=00, ghr=0
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000}, // ghr->1
    {1'b1, 10'h200, 1'b0, 1'b0, 1'b0, 10'h000}, // ctr[200] stays 00
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h001}, // ctr[1] untouched, ghr->2
    {1'b1, 10'h100, 1'b0, 1'b1, 1'b0, 10'h000}, // ctr[100]=00, ghr=200
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 10'h200}  // ctr[200]=00 -> NT, ghr->0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [PC_W-1:0] pc, input logic gsh,
                           output logic t, output logic [K-1:0] h);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; gshare_en = gsh;
    @(negedge clk);
    lk_valid = 1'b0;
    t = pred_taken; h = pred_hist;
  endtask

  task automatic do_resolve(input logic [K-1:0] h, input logic [PC_W-1:0] pc,
                            input logic t, input logic m, input logic gsh,
                            input logic v);
    @(negedge clk);
    rs_valid = v; rs_hist = h; rs_pc = pc; rs_taken = t; rs_mispredict = m;
    gshare_en = gsh;
    @(negedge clk);
    rs_valid = 1'b0; rs_mispredict = 1'b0; rs_taken = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic t;
    logic [K-1:0] h;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pred_valid in reset", pred_valid, 0);
    chk("R1 pred_taken in reset", pred_taken, 0);
    chk("R1 pred_hist in reset", pred_hist, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 pred_valid idle", pred_valid, 0);

    // vector walk, history-only mode (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) begin
        do_resolve(VEC[i][22:13], '0, VEC[i][12], VEC[i][11], 1'b0, 1'b1);
      end else begin
        do_lookup(32'h0000_1234, 1'b0, t, h);
        chk($sformatf("R2 valid vec%0d", i), pred_valid, 1);
        chk($sformatf("R2 R5 direction vec%0d", i), t, VEC[i][10]);
        chk($sformatf("R3 R4 snapshot vec%0d", i), h, VEC[i][9:0]);
      end
    end
    @(negedge clk);
    chk("R2 pred_valid drops", pred_valid, 0);

    // R1 again after reset: counters back to 01, history 0
    apply_reset();
    do_lookup('0, 1'b0, t, h);
    chk("R1 counter reset NT", t, 0);
    chk("R1 history reset", h, 0);

    // R5 low saturation: ctr[0] 01 -> 00 -> 00 -> 00, +1 -> 01 (NT), +1 -> 10 (T)
    // history is 0 after the lookup above predicted NT
    for (int j = 0; j < 3; j++) do_resolve(10'h000, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    do_resolve(10'h000, '0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_lookup('0, 1'b0, t, h);
    chk("R5 low saturation one step up", t, 0);
    chk("R7 history kept by correct resolves", h, 0);
    do_resolve(10'h000, '0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_lookup('0, 1'b0, t, h);
    chk("R5 second step up reaches taken", t, 1);

    // R8 index modes
    apply_reset();
    do_resolve(10'h000, 32'h6, 1'b1, 1'b0, 1'b1, 1'b1); // ctr[3] 10
    do_resolve(10'h000, 32'h6, 1'b1, 1'b0, 1'b1, 1'b1); // ctr[3] 11
    do_lookup(32'h6, 1'b0, t, h);
    chk("R8 plain mode ignores pc", t, 0);
    do_lookup(32'h6, 1'b1, t, h);
    chk("R8 xor mode pc slice", t, 1);
    chk("R8 xor mode snapshot", h, 0);
    do_lookup(32'h4, 1'b1, t, h);      // 1 ^ 2 = 3
    chk("R8 xor mode history^pc", t, 1);
    chk("R3 history after taken", h, 1);
    do_lookup(32'h0, 1'b0, t, h);      // ghr = 3
    chk("R8 plain mode index 3", t, 1);
    chk("R4 snapshot 3", h, 3);

    // R9 same-cycle read and write, ghr = 7, ctr[7] = 01
    @(negedge clk);
    gshare_en = 1'b0; lk_valid = 1'b1; lk_pc = '0;
    rs_valid = 1'b1; rs_hist = 10'h007; rs_pc = '0; rs_taken = 1'b1; rs_mispredict = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0; rs_taken = 1'b0;
    chk("R9 read returns old counter", pred_taken, 0);
    chk("R9 snapshot", pred_hist, 7);
    do_resolve(10'h003, '0, 1'b1, 1'b1, 1'b0, 1'b1); // ghr = 7
    do_lookup('0, 1'b0, t, h);
    chk("R9 write landed", t, 1);
    chk("R6 restored history", h, 7);

    // R6 mispredict wins over same-cycle lookup
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = '0;
    rs_valid = 1'b1; rs_hist = 10'h155; rs_taken = 1'b0; rs_mispredict = 1'b1; rs_pc = '0;
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0; rs_mispredict = 1'b0;
    do_lookup('0, 1'b0, t, h);
    chk("R6 restore priority", h, 10'h2AA);
    chk("R6 counter at restored index", t, 0);

    // R10 resolve fields ignored without rs_valid; ghr now 0x154
    do_resolve(10'h154, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_resolve(10'h154, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_lookup('0, 1'b0, t, h);
    chk("R10 history untouched", h, 10'h154);
    chk("R10 counter untouched", t, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule